// File: doc/BRIEF.md
# Video Mode and Sync Detector

This block watches the horizontal and vertical sync inputs of a graphics input port and reports how they look. For each sync it gives a polarity flag and a missing flag. It also reports two timing counts: the number of lines in a full frame, and the length of one line in reference clock periods. Controller firmware can use these values to recognise the graphics mode that is being applied.

The block runs on the panel clock. The reference clock is a clock enable derived from that clock. In double pixel mode the enable is high on every panel clock. In single pixel mode it is high on every second panel clock. Both sync inputs pass through a two-stage synchronizer before any measurement. Measurement uses the active edge of each sync.

The block keeps a snapshot of the status taken at the last mode change it detected. When a flag differs from that snapshot, or a count moves more than one step away from it, the block treats this as a new mode. It then drives an active-low interrupt. The interrupt stays low until software writes a 1 to the clear bit.

Top module: `sync_mode_det`

## Requirements
- R1: While reset is asserted and on the first clock after its release, all four flags and both counts are 0 and `irq_no` is 1.
- R2: A polarity flag reads 1 when the sync's high phase is shorter than its low phase. The pulse is then active high and its active edge is the falling edge. The flag reads 0 when the low phase is the shorter one, and the active edge is then the rising edge.
- R3: `hmiss_o` becomes 1 when no edge of horizontal sync is seen for `H_TO` reference ticks. It returns to 0 at the next edge.
- R4: `vmiss_o` becomes 1 when no edge of vertical sync is seen for `V_TO` line slots. A line slot is either a horizontal active edge or one horizontal timeout interval. This keeps vertical presence working even when horizontal sync is absent.
- R5: `line_len_o` equals the number of reference ticks between two consecutive horizontal active edges.
- R6: `frame_lines_o` equals the number of line slots between two consecutive vertical active edges.
- R7: With `double_pix_i`=1 a reference tick occurs on every clock. With `double_pix_i`=0 it occurs on every second clock, so the same sync period reports half the line length.
- R8: `irq_no` goes low one clock after any of these events: a flag changes, or a count differs by more than 1 from the snapshot taken at the last detected change.
- R9: A count that differs from the snapshot by exactly 1 does not assert the interrupt.
- R10: Once low, `irq_no` stays low until a cycle with `wr_en_i`=1 and `wr_clr_i`=1. After that cycle it returns high. A write with `wr_clr_i`=0 has no effect. If a new change is detected in the same cycle as a clear, the interrupt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Panel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| double_pix_i | input | 1 | 1: reference tick on every clock; 0: tick on every second clock |
| wr_en_i | input | 1 | Write strobe for the interrupt-clear register |
| wr_clr_i | input | 1 | Write data bit; 1 clears the interrupt |
| hpol_o | output | 1 | Horizontal polarity, 1 = active high |
| vpol_o | output | 1 | Vertical polarity, 1 = active high |
| hmiss_o | output | 1 | Horizontal sync missing |
| vmiss_o | output | 1 | Vertical sync missing |
| line_len_o | output | LEN_W | Line length in reference ticks |
| frame_lines_o | output | LINE_W | Lines per frame |
| irq_no | output | 1 | Mode-change interrupt, active low |

## Verification
The hardest case to reach from the ports is the tolerance window. The bench must move the line length by exactly one tick without the measurement passing through a larger transient value. It does this by lengthening the generated sync period by one clock on a stable mode, after the interrupt has been cleared, and then checking that the interrupt stays high. Next it moves the period four ticks away from the same snapshot and checks that the interrupt does fire. Vertical presence without horizontal sync is reached by stopping only the horizontal generator. Line slots then come from horizontal timeouts alone.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
  typedef struct packed {
    logic vpol;
    logic hpol;
    logic vmiss;
    logic hmiss;
  } sync_flags_t;

  localparam int unsigned JITTER_TOL = 1;
endpackage

// File: rtl/sync_chan.sv
module sync_chan #(
  parameter int unsigned CW = 16,
  parameter int unsigned TO = 65536
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          tick_i,
  output logic          pol_o,
  output logic          miss_o,
  output logic          act_o,
  output logic          to_o,
  output logic [CW-1:0] per_o
);
  localparam int unsigned IW = $clog2(TO) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0]    s_q;
  logic          rise, fall, edge_d;
  logic [CW-1:0] ph_q, hi_q, lo_q, per_q;
  logic          seen_hi_q, seen_lo_q, vld_q;
  logic [IW-1:0] idle_q;
  logic [CW-1:0] hi_n, lo_n;

  assign rise   = s_q[1] & ~s_q[2];
  assign fall   = ~s_q[1] & s_q[2];
  assign edge_d = rise | fall;
  assign act_o  = pol_o ? fall : rise;
  assign to_o   = tick_i & ~edge_d & (idle_q == IW'(TO - 1));
  assign hi_n   = fall ? ph_q : hi_q;
  assign lo_n   = rise ? ph_q : lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q       <= '0;
      ph_q      <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
      pol_o     <= 1'b0;
    end else begin
      s_q <= {s_q[1:0], sync_i};
      if (edge_d) ph_q <= tick_i ? CW'(1) : '0;
      else if (tick_i && ph_q != CMAX) ph_q <= ph_q + 1'b1;
      hi_q <= hi_n;
      lo_q <= lo_n;
      if (fall) seen_hi_q <= 1'b1;
      if (rise) seen_lo_q <= 1'b1;
      // shorter phase is the pulse
      if (edge_d && (seen_hi_q | fall) && (seen_lo_q | rise) && hi_n != lo_n)
        pol_o <= (hi_n < lo_n);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      per_o  <= '0;
      vld_q  <= 1'b0;
      idle_q <= '0;
      miss_o <= 1'b0;
    end else begin
      if (act_o) begin
        per_q <= tick_i ? CW'(1) : '0;
        vld_q <= 1'b1;
        if (vld_q) per_o <= per_q;
      end else if (tick_i && per_q != CMAX) begin
        per_q <= per_q + 1'b1;
      end
      if (edge_d) begin
        idle_q <= '0;
        miss_o <= 1'b0;
      end else if (to_o) begin
        idle_q <= '0;
        miss_o <= 1'b1;
        vld_q  <= 1'b0;
      end else if (tick_i) begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mode_cmp.sv
module mode_cmp
  import mdet_pkg::*;
#(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sync_flags_t       flags_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wr_en_i,
  input  logic              wr_clr_i,
  output logic              irq_no
);
  sync_flags_t       snap_flags_q;
  logic [LINE_W-1:0] snap_lines_q, d_lines;
  logic [LEN_W-1:0]  snap_len_q, d_len;
  logic              chg, irq_q;

  assign d_lines = (lines_i > snap_lines_q) ? lines_i - snap_lines_q : snap_lines_q - lines_i;
  assign d_len   = (len_i > snap_len_q) ? len_i - snap_len_q : snap_len_q - len_i;
  assign chg     = (flags_i != snap_flags_q) ||
                   (d_lines > LINE_W'(JITTER_TOL)) ||
                   (d_len > LEN_W'(JITTER_TOL));
  assign irq_no  = ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_flags_q <= '0;
      snap_lines_q <= '0;
      snap_len_q   <= '0;
      irq_q        <= 1'b0;
    end else begin
      if (chg) begin
        snap_flags_q <= flags_i;
        snap_lines_q <= lines_i;
        snap_len_q   <= len_i;
      end
      // set beats clear
      if (chg) irq_q <= 1'b1;
      else if (wr_en_i && wr_clr_i) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_mode_det.sv
module sync_mode_det
  import mdet_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LINE_W = 12,
  parameter int unsigned H_TO   = 65536,
  parameter int unsigned V_TO   = 4095
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              double_pix_i,
  input  logic              wr_en_i,
  input  logic              wr_clr_i,
  output logic              hpol_o,
  output logic              vpol_o,
  output logic              hmiss_o,
  output logic              vmiss_o,
  output logic [LEN_W-1:0]  line_len_o,
  output logic [LINE_W-1:0] frame_lines_o,
  output logic              irq_no
);
  logic        half_q, ref_tick;
  logic        h_act, h_to, line_tick;
  logic        v_act, v_to;
  sync_flags_t flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end
  assign ref_tick  = double_pix_i | half_q;
  assign line_tick = h_act | h_to;

  sync_chan #(.CW(LEN_W), .TO(H_TO)) h_chan_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (hsync_i),
    .tick_i (ref_tick),
    .pol_o  (hpol_o),
    .miss_o (hmiss_o),
    .act_o  (h_act),
    .to_o   (h_to),
    .per_o  (line_len_o)
  );

  sync_chan #(.CW(LINE_W), .TO(V_TO)) v_chan_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (vsync_i),
    .tick_i (line_tick),
    .pol_o  (vpol_o),
    .miss_o (vmiss_o),
    .act_o  (v_act),
    .to_o   (v_to),
    .per_o  (frame_lines_o)
  );

  assign flags = '{vpol: vpol_o, hpol: hpol_o, vmiss: vmiss_o, hmiss: hmiss_o};

  mode_cmp #(.LINE_W(LINE_W), .LEN_W(LEN_W)) cmp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags),
    .lines_i  (frame_lines_o),
    .len_i    (line_len_o),
    .wr_en_i  (wr_en_i),
    .wr_clr_i (wr_clr_i),
    .irq_no   (irq_no)
  );
endmodule

// File: rtl/sync_mode_det_chk.sv
module sync_mode_det_chk #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LINE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_clr_i,
  input logic              hpol_o,
  input logic              vpol_o,
  input logic              hmiss_o,
  input logic              vmiss_o,
  input logic [LEN_W-1:0]  line_len_o,
  input logic [LINE_W-1:0] frame_lines_o,
  input logic              irq_no
);
  // R8
  flag_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({vpol_o, hpol_o, vmiss_o, hmiss_o}) |=> !irq_no);

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |->
      ($past({vpol_o, hpol_o, vmiss_o, hmiss_o, line_len_o, frame_lines_o}) !=
       $past({vpol_o, hpol_o, vmiss_o, hmiss_o, line_len_o, frame_lines_o}, 2)));

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !(wr_en_i && wr_clr_i)) |=> !irq_no);

  // R10
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(wr_en_i && wr_clr_i));
endmodule

bind sync_mode_det sync_mode_det_chk #(.LEN_W(LEN_W), .LINE_W(LINE_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_clr_i      (wr_clr_i),
  .hpol_o        (hpol_o),
  .vpol_o        (vpol_o),
  .hmiss_o       (hmiss_o),
  .vmiss_o       (vmiss_o),
  .line_len_o    (line_len_o),
  .frame_lines_o (frame_lines_o),
  .irq_no        (irq_no)
);

// File: tb/sync_mode_det_tb_top.sv
module sync_mode_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W  = 12;
  localparam int LINE_W = 10;
  localparam int H_TO   = 512;
  localparam int V_TO   = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic double_pix = 1'b1, wr_en = 1'b0, wr_clr = 1'b0;
  logic hpol, vpol, hmiss, vmiss, irq_n;
  logic [LEN_W-1:0]  line_len;
  logic [LINE_W-1:0] frame_lines;

  int  h_period = 100, h_pulse = 10, v_total = 20, v_pulse = 3;
  logic h_pol = 1'b1, v_pol = 1'b1, h_en = 1'b1, v_en = 1'b1;
  int  hcnt = 0, lcnt = 0;
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_mode_det #(.LEN_W(LEN_W), .LINE_W(LINE_W), .H_TO(H_TO), .V_TO(V_TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync), .vsync_i(vsync),
    .double_pix_i(double_pix), .wr_en_i(wr_en), .wr_clr_i(wr_clr),
    .hpol_o(hpol), .vpol_o(vpol), .hmiss_o(hmiss), .vmiss_o(vmiss),
    .line_len_o(line_len), .frame_lines_o(frame_lines), .irq_no(irq_n)
  );

  // sync generator
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (hcnt >= h_period - 1) begin
        hcnt = 0;
        lcnt = (lcnt >= v_total - 1) ? 0 : lcnt + 1;
      end else hcnt++;
      hsync = h_en ? ((hcnt < h_pulse) ~^ h_pol) : 1'b0;
      vsync = v_en ? ((lcnt < v_pulse) ~^ v_pol) : 1'b0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(int n);
    wait_cyc(n * h_period * v_total);
  endtask

  task automatic clear_irq();
    wr_en = 1'b1; wr_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    wait_cyc(5);
    chk("R1 irq in reset", irq_n, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 flags", {hpol, vpol, hmiss, vmiss}, 0);
    chk("R1 line_len", line_len, 0);
    chk("R1 frame_lines", frame_lines, 0);
    chk("R1 irq", irq_n, 1);
  endtask

  task automatic t_lock_high();
    frames(5);
    chk("R2 hpol high", hpol, 1);
    chk("R2 vpol high", vpol, 1);
    chk("R5 line_len", line_len, 100);
    chk("R6 frame_lines", frame_lines, 20);
    chk("R8 irq on new mode", irq_n, 0);
    clear_irq();
    chk("R10 cleared", irq_n, 1);
    frames(2);
    chk("R10 stays clear on steady mode", irq_n, 1);
  endtask

  task automatic t_tolerance();
    h_period = 101;
    frames(3);
    chk("R5 line_len 101", line_len, 101);
    chk("R9 one-step drift no irq", irq_n, 1);
    h_period = 104;
    frames(3);
    chk("R5 line_len 104", line_len, 104);
    chk("R8 large step irq", irq_n, 0);
    h_period = 100;
    frames(3);
    clear_irq();
  endtask

  task automatic t_low_pol();
    h_pol = 1'b0; v_pol = 1'b0;
    frames(5);
    chk("R2 hpol low", hpol, 0);
    chk("R2 vpol low", vpol, 0);
    chk("R5 line_len low pol", line_len, 100);
    chk("R6 frame_lines low pol", frame_lines, 20);
    chk("R8 irq on polarity", irq_n, 0);
    clear_irq();
    frames(1);
    chk("R10 clear after polarity", irq_n, 1);
  endtask

  task automatic t_single();
    double_pix = 1'b0;
    frames(4);
    chk("R7 half line_len", line_len, 50);
    chk("R7 frame_lines unchanged", frame_lines, 20);
    chk("R8 irq on length", irq_n, 0);
    wr_en = 1'b1; wr_clr = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    wait_cyc(3);
    chk("R10 write of 0 ignored", irq_n, 0);
    clear_irq();
    chk("R10 clear", irq_n, 1);
    double_pix = 1'b1;
    frames(4);
    clear_irq();
  endtask

  task automatic t_hmiss();
    h_en = 1'b0;
    wait_cyc(H_TO + 20);
    chk("R3 hmiss set", hmiss, 1);
    chk("R8 irq on hmiss", irq_n, 0);
    frames(2);
    chk("R4 vsync present via timeout slots", vmiss, 0);
    h_en = 1'b1;
    frames(4);
    chk("R3 hmiss cleared", hmiss, 0);
    chk("R5 line_len after return", line_len, 100);
    clear_irq();
  endtask

  task automatic t_vmiss();
    v_en = 1'b0;
    wait_cyc((V_TO + 4) * h_period);
    chk("R4 vmiss set", vmiss, 1);
    chk("R8 irq on vmiss", irq_n, 0);
    v_en = 1'b1;
    frames(4);
    chk("R4 vmiss cleared", vmiss, 0);
    chk("R6 frame_lines after return", frame_lines, 20);
  endtask

  initial begin
    t_reset();
    t_lock_high();
    t_tolerance();
    t_low_pol();
    t_single();
    t_hmiss();
    t_vmiss();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule